// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM command bus and brings the memory from reset to the all-banks-idle state. After reset release it holds the clock enable low and drives a no-operation command while a long start-up interval elapses. It then raises the clock enable and walks a fixed script of commands, one at a time, each followed by no-operation cycles:

1. Precharge-all.
2. Extended mode write that turns the DLL on.
3. Mode write that also resets the DLL.
4. A second precharge-all.
5. A programmable number of auto refreshes.
6. A final mode write that loads the operating mode with the DLL-reset bit cleared.

Every interval is a parameter counted in clock cycles. These are the start-up wait, precharge recovery, mode-write recovery, refresh cycle time and the DLL lock interval. Both mode words are parameters.

The states are `ST_STARTUP`, `ST_CKE_ON`, `ST_PRE_A`, `ST_PRE_A_GAP`, `ST_EXT_MR`, `ST_EXT_MR_GAP`, `ST_DLL_MR`, `ST_DLL_MR_GAP`, `ST_PRE_B`, `ST_PRE_B_GAP`, `ST_REF`, `ST_REF_GAP`, `ST_OP_MR`, `ST_FINAL` and `ST_READY`. Each command state lasts exactly one cycle and moves to the gap state that follows it. `ST_STARTUP` leaves when the start-up count expires. `ST_CKE_ON` is one cycle. Each gap state leaves when its recovery count expires. `ST_REF_GAP` loops back to `ST_REF` until the programmed number of refreshes has been issued, then goes to `ST_OP_MR`. `ST_FINAL` leaves to `ST_READY` only when both the mode-write recovery and the DLL lock interval have expired. `ST_READY` holds until reset.

In `ST_READY` the done flag is high. The normal scheduler takes the command bus from that cycle on.

Top module: `ddr_init_seq`

## Requirements
Cycle k counts rising clock edges since reset release. S = T_STARTUP. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP = 0111, precharge = 0010, auto refresh = 0001, mode write = 0000. In NOP cycles, ba and addr are zero.

- R1: For cycles 0 to S-1, cke is 0, the bus carries NOP and init_done is 0.
- R2: cke rises in cycle S with a NOP on the bus, and stays 1 until reset.
- R3: The first precharge is issued in cycle S+1 with addr bit 10 set and every other addr bit zero.
- R4: T_RP cycles after the first precharge, a mode write goes out with ba = 01. Its addr is EXT_MODE_WORD with bit 0 forced to 0, which enables the DLL.
- R5: T_MRD cycles later, a mode write goes out with ba = 00 and addr = MODE_WORD with bit 8 (DLL reset) set.
- R6: T_MRD cycles after the DLL-reset write, a second precharge is issued with addr bit 10 set.
- R7: N_REF auto refreshes follow. The first comes T_RP cycles after the second precharge, and each later one comes T_RFC cycles after the previous one.
- R8: T_RFC cycles after the last refresh, a mode write goes out with ba = 00 and addr = MODE_WORD with bit 8 cleared.
- R9: Every cycle that is not one of the commands above carries NOP. No two commands are issued on adjacent cycles.
- R10: init_done rises in cycle max(final write + T_MRD, DLL-reset write + T_DLL) and stays 1 until reset. While it is 1, the bus carries NOP with cke = 1.
- R11: Asserting rst_n low at any point immediately returns the outputs to the R1 state. A later release restarts the whole script from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe command bit |
| cas_n | output | 1 | Column strobe command bit |
| we_n | output | 1 | Write-enable command bit |
| ba | output | BA_W | Bank address (selects the mode register on writes) |
| addr | output | ADDR_W | Address bus (mode word or precharge-all flag) |
| init_done | output | 1 | High once the memory may accept normal commands |

## Verification
A wrong state or a miscounted timer shows up at the command pins as a command issued in the wrong cycle, a command that is missing, or a wrong bank or address value. The bench compares the bus against a schedule computed from the parameters in every cycle, so any such slip is caught in the exact cycle where the first command moves. A fault in the DLL lock timer shows only on init_done. Two configurations are run, one where the DLL interval dominates the done cycle and one where the mode-write recovery dominates, so each bound is exposed. The bench also applies a reset in mid-script to show that it restarts cleanly.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_STARTUP,
        ST_CKE_ON,
        ST_PRE_A,
        ST_PRE_A_GAP,
        ST_EXT_MR,
        ST_EXT_MR_GAP,
        ST_DLL_MR,
        ST_DLL_MR_GAP,
        ST_PRE_B,
        ST_PRE_B_GAP,
        ST_REF,
        ST_REF_GAP,
        ST_OP_MR,
        ST_FINAL,
        ST_READY
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } ddr_cmd_e;

    // Address bit that resets the DLL in the base mode word.
    localparam int DLL_RESET_BIT = 8;
    // Address bit that widens a precharge to all banks.
    localparam int PRE_ALL_BIT   = 10;
    // Extended-mode bit that disables the DLL when set.
    localparam int DLL_OFF_BIT   = 0;

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
    parameter int unsigned W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Down-counter that parks at zero; a load wins over the decrement.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RST_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_encode.sv
module init_cmd_encode
    import ddr_init_pkg::*;
(
    input  ddr_cmd_e cmd,
    output logic     cs_n,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n
);

    always_comb begin
        unique case (cmd)
            CMD_PRE: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            CMD_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_MRS: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned T_STARTUP     = 40000,
    parameter int unsigned T_RP          = 3,
    parameter int unsigned T_MRD         = 2,
    parameter int unsigned T_RFC         = 15,
    parameter int unsigned T_DLL         = 200,
    parameter int unsigned N_REF         = 2,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned ADDR_W        = 13,
    parameter logic [ADDR_W-1:0] MODE_WORD     = 13'h062,
    parameter logic [ADDR_W-1:0] EXT_MODE_WORD = 13'h000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    // Every recovery count must be at least 2: one command cycle plus one or more NOPs.
    localparam int unsigned GAP_MAX_A = (T_STARTUP > T_RFC) ? T_STARTUP : T_RFC;
    localparam int unsigned GAP_MAX_B = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int unsigned GAP_MAX   = (GAP_MAX_A > GAP_MAX_B) ? GAP_MAX_A : GAP_MAX_B;
    localparam int unsigned GAP_W     = $clog2(GAP_MAX + 1);
    localparam int unsigned DLL_W     = $clog2(T_DLL + 1);
    localparam int unsigned REF_W     = $clog2(N_REF + 1);

    localparam logic [ADDR_W-1:0] ONE_BIT       = {{(ADDR_W-1){1'b0}}, 1'b1};
    localparam logic [ADDR_W-1:0] DLL_RST_MASK  = ONE_BIT << DLL_RESET_BIT;
    localparam logic [ADDR_W-1:0] DLL_OFF_MASK  = ONE_BIT << DLL_OFF_BIT;
    localparam logic [ADDR_W-1:0] PRE_ALL_ADDR  = ONE_BIT << PRE_ALL_BIT;
    localparam logic [ADDR_W-1:0] MR_DLL_RESET  = MODE_WORD | DLL_RST_MASK;
    localparam logic [ADDR_W-1:0] MR_OPERATE    = MODE_WORD & ~DLL_RST_MASK;
    localparam logic [ADDR_W-1:0] EMR_DLL_ON    = EXT_MODE_WORD & ~DLL_OFF_MASK;
    localparam logic [BA_W-1:0]   BA_BASE_MR    = '0;
    localparam logic [BA_W-1:0]   BA_EXT_MR     = {{(BA_W-1){1'b0}}, 1'b1};

    localparam logic [GAP_W-1:0]  START_LOAD    = GAP_W'(T_STARTUP - 1);
    localparam logic [GAP_W-1:0]  RP_LOAD       = GAP_W'(T_RP - 2);
    localparam logic [GAP_W-1:0]  MRD_LOAD      = GAP_W'(T_MRD - 2);
    localparam logic [GAP_W-1:0]  RFC_LOAD      = GAP_W'(T_RFC - 2);
    localparam logic [DLL_W-1:0]  DLL_LOAD      = DLL_W'(T_DLL - 2);

    seq_state_e       state_q, state_d;
    logic [REF_W-1:0] ref_cnt_q;
    logic             gap_load;
    logic [GAP_W-1:0] gap_val;
    logic             gap_exp;
    logic             dll_load;
    logic             dll_exp;
    ddr_cmd_e         cmd;

    // Shared recovery timer; its reset value covers the start-up wait.
    init_wait_timer #(
        .W       (GAP_W),
        .RST_VAL (START_LOAD)
    ) u_gap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_exp)
    );

    // DLL lock interval runs beside the rest of the script.
    init_wait_timer #(
        .W       (DLL_W),
        .RST_VAL ('0)
    ) u_dll_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dll_load),
        .load_val (DLL_LOAD),
        .expired  (dll_exp)
    );

    init_cmd_encode u_encode (
        .cmd   (cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    // Next state and timer loads.
    always_comb begin
        state_d  = state_q;
        gap_load = 1'b0;
        gap_val  = MRD_LOAD;
        dll_load = 1'b0;
        unique case (state_q)
            ST_STARTUP:    if (gap_exp) state_d = ST_CKE_ON;
            ST_CKE_ON:     state_d = ST_PRE_A;
            ST_PRE_A: begin
                state_d  = ST_PRE_A_GAP;
                gap_load = 1'b1;
                gap_val  = RP_LOAD;
            end
            ST_PRE_A_GAP:  if (gap_exp) state_d = ST_EXT_MR;
            ST_EXT_MR: begin
                state_d  = ST_EXT_MR_GAP;
                gap_load = 1'b1;
                gap_val  = MRD_LOAD;
            end
            ST_EXT_MR_GAP: if (gap_exp) state_d = ST_DLL_MR;
            ST_DLL_MR: begin
                state_d  = ST_DLL_MR_GAP;
                gap_load = 1'b1;
                gap_val  = MRD_LOAD;
                dll_load = 1'b1;
            end
            ST_DLL_MR_GAP: if (gap_exp) state_d = ST_PRE_B;
            ST_PRE_B: begin
                state_d  = ST_PRE_B_GAP;
                gap_load = 1'b1;
                gap_val  = RP_LOAD;
            end
            ST_PRE_B_GAP:  if (gap_exp) state_d = ST_REF;
            ST_REF: begin
                state_d  = ST_REF_GAP;
                gap_load = 1'b1;
                gap_val  = RFC_LOAD;
            end
            ST_REF_GAP: begin
                if (gap_exp) begin
                    state_d = (ref_cnt_q == REF_W'(N_REF)) ? ST_OP_MR : ST_REF;
                end
            end
            ST_OP_MR: begin
                state_d  = ST_FINAL;
                gap_load = 1'b1;
                gap_val  = MRD_LOAD;
            end
            ST_FINAL:      if (gap_exp && dll_exp) state_d = ST_READY;
            ST_READY:      state_d = ST_READY;
            default:       state_d = ST_STARTUP;
        endcase
    end

    // State register and refresh tally.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_STARTUP;
            ref_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REF) begin
                ref_cnt_q <= ref_cnt_q + 1'b1;
            end
        end
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        cke       = (state_q != ST_STARTUP);
        init_done = (state_q == ST_READY);
        cmd       = CMD_NOP;
        ba        = '0;
        addr      = '0;
        unique case (state_q)
            ST_PRE_A, ST_PRE_B: begin
                cmd  = CMD_PRE;
                addr = PRE_ALL_ADDR;
            end
            ST_EXT_MR: begin
                cmd  = CMD_MRS;
                ba   = BA_EXT_MR;
                addr = EMR_DLL_ON;
            end
            ST_DLL_MR: begin
                cmd  = CMD_MRS;
                ba   = BA_BASE_MR;
                addr = MR_DLL_RESET;
            end
            ST_OP_MR: begin
                cmd  = CMD_MRS;
                ba   = BA_BASE_MR;
                addr = MR_OPERATE;
            end
            ST_REF:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk #(
    parameter int unsigned BA_W   = 2,
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    logic is_nop, is_pre, is_ext_mr;
    assign is_nop    = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
    assign is_pre    = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
    assign is_ext_mr = ({cs_n, ras_n, cas_n, we_n} == 4'b0000) && (ba == BA_W'(1));

    assert_startup_nop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (is_nop && !init_done));

    assert_cke_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    assert_prea_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> addr[10]);

    assert_ext_dll_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_ext_mr |-> !addr[0]);

    assert_single_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop);

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (is_nop && cke));

endmodule

bind ddr_init_seq ddr_init_seq_chk #(
    .BA_W   (BA_W),
    .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        cke;
        logic [3:0]  pins;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        done;
        int          req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic        a_cke, a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0]  a_ba;
    logic [12:0] a_addr;
    logic        b_cke, b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0]  b_ba;
    logic [12:0] b_addr;

    // DLL interval dominates the done cycle here.
    ddr_init_seq #(
        .T_STARTUP(20), .T_RP(3), .T_MRD(2), .T_RFC(7), .T_DLL(30), .N_REF(2),
        .MODE_WORD(13'h062), .EXT_MODE_WORD(13'h001)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cke(a_cke), .cs_n(a_cs), .ras_n(a_ras),
        .cas_n(a_cas), .we_n(a_we), .ba(a_ba), .addr(a_addr), .init_done(a_done)
    );

    // Mode-write recovery dominates the done cycle here.
    ddr_init_seq #(
        .T_STARTUP(12), .T_RP(2), .T_MRD(3), .T_RFC(5), .T_DLL(4), .N_REF(3),
        .MODE_WORD(13'h132), .EXT_MODE_WORD(13'h002)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .cke(b_cke), .cs_n(b_cs), .ras_n(b_ras),
        .cas_n(b_cas), .we_n(b_we), .ba(b_ba), .addr(b_addr), .init_done(b_done)
    );

    function automatic exp_t expect_at(int k, int ts, int trp, int tmrd, int trfc,
                                       int tdll, int nref, logic [12:0] mode,
                                       logic [12:0] ext);
        exp_t e;
        int p1, em, dm, p2, r0, om, dn;
        p1 = ts + 1;
        em = p1 + trp;
        dm = em + tmrd;
        p2 = dm + tmrd;
        r0 = p2 + trp;
        om = r0 + nref * trfc;
        dn = (om + tmrd > dm + tdll) ? om + tmrd : dm + tdll;
        e.cke  = (k >= ts);
        e.pins = 4'b0111;
        e.ba   = 2'b00;
        e.addr = '0;
        e.done = (k >= dn);
        e.req  = (k < ts) ? 1 : 9;                   // R1 start-up / R9 gaps
        if (k == ts) e.req = 2;                      // R2 cke rise
        if (k == p1) begin                           // R3 first precharge-all
            e.pins = 4'b0010; e.addr = 13'h0400; e.req = 3;
        end
        if (k == em) begin                           // R4 extended mode, DLL on
            e.pins = 4'b0000; e.ba = 2'b01; e.addr = ext & ~13'h0001; e.req = 4;
        end
        if (k == dm) begin                           // R5 mode with DLL reset
            e.pins = 4'b0000; e.addr = mode | 13'h0100; e.req = 5;
        end
        if (k == p2) begin                           // R6 second precharge-all
            e.pins = 4'b0010; e.addr = 13'h0400; e.req = 6;
        end
        for (int i = 0; i < nref; i++) begin         // R7 refreshes
            if (k == r0 + i * trfc) begin
                e.pins = 4'b0001; e.req = 7;
            end
        end
        if (k == om) begin                           // R8 operating mode write
            e.pins = 4'b0000; e.addr = mode & ~13'h0100; e.req = 8;
        end
        return e;
    endfunction

    task automatic compare(string who, int k, int req_bus, exp_t e,
                           logic cke, logic [3:0] pins, logic [1:0] ba,
                           logic [12:0] addr, logic done);
        checks++;
        if ({cke, pins, ba, addr} !== {e.cke, e.pins, e.ba, e.addr}) begin
            fails++;
            $display("FAIL R%0d %s cycle %0d bus: got cke=%b cmd=%b ba=%b addr=%h expected cke=%b cmd=%b ba=%b addr=%h",
                     req_bus, who, k, cke, pins, ba, addr, e.cke, e.pins, e.ba, e.addr);
        end
        checks++;
        if (done !== e.done) begin
            fails++;
            $display("FAIL R10 %s cycle %0d init_done: got %b expected %b", who, k, done, e.done);
        end
    endtask

    task automatic check_cycle(int k, int req_override);
        exp_t ea, eb;
        ea = expect_at(k, 20, 3, 2, 7, 30, 2, 13'h062, 13'h001);
        eb = expect_at(k, 12, 2, 3, 5, 4, 3, 13'h132, 13'h002);
        compare("u0", k, (req_override != 0) ? req_override : ea.req, ea,
                a_cke, {a_cs, a_ras, a_cas, a_we}, a_ba, a_addr, a_done);
        compare("u1", k, (req_override != 0) ? req_override : eb.req, eb,
                b_cke, {b_cs, b_ras, b_cas, b_we}, b_ba, b_addr, b_done);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        report();
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_cycle(0, 11);                          // R11 reset state
        rst_n = 1'b1;
        // Partial run, cut off mid-script.
        for (int k = 0; k < 35; k++) begin
            check_cycle(k, 0);
            @(negedge clk);
        end
        // R11: mid-script reset returns to the start-up state at once.
        rst_n = 1'b0;
        #1;
        check_cycle(0, 11);
        @(negedge clk);
        check_cycle(0, 11);
        @(negedge clk);
        rst_n = 1'b1;
        // Full run from the restart, covering done and the quiet tail.
        for (int k = 0; k < 70; k++) begin
            check_cycle(k, 0);
            @(negedge clk);
        end
        report();
    end

endmodule